// File: doc/BRIEF.md
# Auto-Increment Memory Access Port

This block sits between a byte-wide register interface and a large work memory. Software uses it to reach any byte of a 128 KiB region through one data register. First it loads a 17-bit pointer through three byte-sized pointer registers. It then reads or writes the data register as often as it needs. Each data access goes to the byte the pointer names, and the pointer then steps forward by one. A run of consecutive bytes can therefore be streamed without reloading the address.

Each pointer register changes only its own slice of the pointer and leaves the other bits unchanged. Software can therefore move just the low byte of the address, for example, without rewriting the rest. On the memory side the block issues a single-cycle request. The request carries a 24-bit address, formed by placing the pointer inside a fixed bank base of 0x7E0000, a write-enable and write data. Read data returns one cycle after the request. It is presented on the register read port one cycle after that.

Top module: `indirect_mem_port`

## Requirements
- R1: A write with `reg_sel` = 1 replaces pointer bits 7:0 with the written byte. Pointer bits 16:8 stay as they were.
- R2: A write with `reg_sel` = 2 replaces pointer bits 15:8 with the written byte. Pointer bits 16 and 7:0 stay as they were.
- R3: A write with `reg_sel` = 3 copies bit 0 of the written byte into pointer bit 16. Bits 7:1 of that byte have no effect, and pointer bits 15:0 stay as they were.
- R4: A write access with `reg_sel` = 0 raises `mem_req` for one cycle with `mem_we` = 1 and `mem_wdata` equal to the written byte, at the current pointer. The pointer then advances by one.
- R5: A read access with `reg_sel` = 0 raises `mem_req` for one cycle with `mem_we` = 0 at the current pointer, and the pointer then advances by one. The byte returned on `mem_rdata` in the cycle after the request appears on `reg_rdata` one cycle later and is held there.
- R6: While `mem_req` is high, `mem_addr` equals 0x7E0000 ORed with the 17-bit pointer.
- R7: Advancing the pointer from 0x1FFFF gives 0x00000.
- R8: An access counts only on the rising edge of `reg_rd | reg_wr`. If the strobe is held high for several cycles, the block issues exactly one memory request and advances the pointer exactly once.
- R9: After reset the pointer is 0x00000, `mem_req` is low and `reg_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 data, 1 pointer low, 2 pointer middle, 3 pointer high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Last byte fetched through the data register |
| mem_req | output | 1 | Single-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid the cycle after a read request |

## Verification
The pointer cannot be read directly, so its value can only be seen in `mem_addr` during the next data access. Each pointer-register scenario therefore ends with a probe access, and the address of that access is compared against the merged value the bench expects. The hardest case to reach is the 0x1FFFF wrap. The bench gets there by writing all three pointer registers to their maximum values, then makes two accesses back to back. The held-strobe case keeps `reg_wr` high over several edges, confirms that `mem_req` stays low in each of those cycles, and checks that the next access sits only one byte further on.

// File: rtl/imp_pkg.sv
package imp_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_DATA = 2'd0;
  localparam logic [SEL_W-1:0] SEL_LOW  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_MID  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_HIGH = 2'd3;
endpackage

// File: rtl/imp_rst_sync.sv
module imp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/imp_strobe_edge.sv
module imp_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fire
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign fire = strobe & ~strobe_q;
endmodule

// File: rtl/imp_ptr_reg.sv
module imp_ptr_reg #(
  parameter int PTR_W  = 17,
  parameter int DATA_W = 8,
  localparam int NLANES = (PTR_W + DATA_W - 1) / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLANES-1:0] lane_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              inc,
  output logic [PTR_W-1:0]  ptr
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_d = ptr_q;
    if (|lane_wr) begin
      for (int b = 0; b < PTR_W; b++) begin
        if (lane_wr[b / DATA_W]) ptr_d[b] = wdata[b % DATA_W];
      end
    end else if (inc) begin
      ptr_d = ptr_q + PTR_W'(1);
    end
  end

  assign ptr_en = (|lane_wr) | inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/imp_rd_capture.sv
module imp_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rdata
);
  logic              pend_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (pend_q) hold_q <= mem_rdata;
  end

  assign rdata = hold_q;
endmodule

// File: rtl/indirect_mem_port.sv
module indirect_mem_port #(
  parameter int              PTR_W     = 17,
  parameter int              DATA_W    = 8,
  parameter int              ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BANK_BASE = 24'h7E0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [imp_pkg::SEL_W-1:0] reg_sel,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic [DATA_W-1:0]        mem_rdata
);
  import imp_pkg::*;

  localparam int NLANES = (PTR_W + DATA_W - 1) / DATA_W;

  logic              rst_sync_n;
  logic              strobe;
  logic              fire;
  logic              data_fire;
  logic [NLANES-1:0] lane_wr;
  logic [PTR_W-1:0]  ptr;

  imp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign strobe = reg_wr | reg_rd;

  imp_strobe_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .strobe (strobe),
    .fire   (fire)
  );

  assign data_fire = fire & (reg_sel == SEL_DATA);

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign lane_wr[g] = fire & reg_wr & (reg_sel == SEL_W'(g + 1));
  end

  imp_ptr_reg #(
    .PTR_W  (PTR_W),
    .DATA_W (DATA_W)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lane_wr (lane_wr),
    .wdata   (reg_wdata),
    .inc     (data_fire),
    .ptr     (ptr)
  );

  imp_rd_capture #(
    .DATA_W (DATA_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_req    (data_fire & ~reg_wr),
    .mem_rdata (mem_rdata),
    .rdata     (reg_rdata)
  );

  assign mem_req   = data_fire;
  assign mem_we    = reg_wr;
  assign mem_wdata = reg_wdata;
  assign mem_addr  = BANK_BASE | ADDR_W'(ptr);
endmodule

// File: rtl/imp_port_checker.sv
module imp_port_checker #(
  parameter int              PTR_W     = 17,
  parameter int              DATA_W    = 8,
  parameter int              ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BANK_BASE = 24'h7E0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PTR_W-1:0]  ptr
);
  assert_low_merge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !$past(strobe) && reg_wr && reg_sel == 2'd1)
    |=> (ptr[DATA_W-1:0] == $past(reg_wdata) && ptr[PTR_W-1:DATA_W] == $past(ptr[PTR_W-1:DATA_W])));

  assert_mid_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !$past(strobe) && reg_wr && reg_sel == 2'd2)
    |=> (ptr[2*DATA_W-1:DATA_W] == $past(reg_wdata) && ptr[PTR_W-1] == $past(ptr[PTR_W-1])
         && ptr[DATA_W-1:0] == $past(ptr[DATA_W-1:0])));

  assert_high_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !$past(strobe) && reg_wr && reg_sel == 2'd3)
    |=> (ptr[PTR_W-1] == $past(reg_wdata[0]) && ptr[PTR_W-2:0] == $past(ptr[PTR_W-2:0])));

  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> ptr == PTR_W'($past(ptr) + 1));

  assert_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[ADDR_W-1:PTR_W] == BANK_BASE[ADDR_W-1:PTR_W]);

  assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |-> !mem_req);
endmodule

bind indirect_mem_port imp_port_checker #(
  .PTR_W     (PTR_W),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .BANK_BASE (BANK_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .strobe    (strobe),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .ptr       (ptr)
);

// File: tb/indirect_mem_port_bench.sv
module indirect_mem_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        reg_wr;
  logic        reg_rd;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  logic [7:0]  mem [0:1023];
  int nvec  = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  indirect_mem_port u_indirect_mem_port (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_ptr(input logic [16:0] p);
    wr_reg(2'd3, {7'd0, p[16]});
    wr_reg(2'd2, p[15:8]);
    wr_reg(2'd1, p[7:0]);
  endtask

  task automatic access(input bit wr, input logic [7:0] d,
                        output logic [23:0] a, output logic req, output logic we);
    @(negedge clk);
    reg_sel = 2'd0; reg_wr = wr; reg_rd = !wr; reg_wdata = d;
    #1;
    a = mem_addr; req = mem_req; we = mem_we;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [23:0] a; logic rq, we;
    chk("R9 rdata", {24'd0, reg_rdata}, 32'h0);
    chk("R9 req", {31'd0, mem_req}, 32'h0);
    access(1'b0, 8'h00, a, rq, we);
    chk("R9 ptr", {8'd0, a}, 32'h7E0000);
  endtask

  task automatic t_low;
    logic [23:0] a; logic rq, we;
    wr_reg(2'd1, 8'h34);
    access(1'b1, 8'hA5, a, rq, we);
    chk("R1 low", {8'd0, a}, 32'h7E0034);
    chk("R6 req", {31'd0, rq}, 32'h1);
    access(1'b1, 8'hA6, a, rq, we);
    chk("R4 next", {8'd0, a}, 32'h7E0035);
  endtask

  task automatic t_mid;
    logic [23:0] a; logic rq, we;
    set_ptr(17'h12345);
    wr_reg(2'd2, 8'hAB);
    access(1'b1, 8'h01, a, rq, we);
    chk("R2 mid", {8'd0, a}, 32'h7FAB45);
  endtask

  task automatic t_high;
    logic [23:0] a; logic rq, we;
    wr_reg(2'd3, 8'hFE);
    access(1'b1, 8'h02, a, rq, we);
    chk("R3 high0", {8'd0, a}, 32'h7EAB46);
    wr_reg(2'd3, 8'h03);
    access(1'b1, 8'h03, a, rq, we);
    chk("R3 high1", {8'd0, a}, 32'h7FAB47);
  endtask

  task automatic t_stream;
    logic [23:0] a; logic rq, we;
    set_ptr(17'h00100);
    for (int i = 0; i < 3; i++) begin
      access(1'b1, 8'h11 * (i + 1), a, rq, we);
      chk("R4 waddr", {8'd0, a}, 32'h7E0100 + i);
      chk("R4 we", {31'd0, we}, 32'h1);
    end
    set_ptr(17'h00100);
    for (int i = 0; i < 3; i++) begin
      access(1'b0, 8'h00, a, rq, we);
      chk("R5 raddr", {8'd0, a}, 32'h7E0100 + i);
      chk("R5 we", {31'd0, we}, 32'h0);
      chk("R5 rdata", {24'd0, reg_rdata}, 32'h11 * (i + 1));
    end
  endtask

  task automatic t_wrap;
    logic [23:0] a; logic rq, we;
    set_ptr(17'h1FFFF);
    access(1'b1, 8'h5A, a, rq, we);
    chk("R7 top", {8'd0, a}, 32'h7FFFFF);
    access(1'b1, 8'h5B, a, rq, we);
    chk("R7 wrap", {8'd0, a}, 32'h7E0000);
  endtask

  task automatic t_hold;
    logic [23:0] a; logic rq, we;
    set_ptr(17'h00200);
    @(negedge clk);
    reg_sel = 2'd0; reg_wr = 1'b1; reg_wdata = 8'h77;
    #1;
    chk("R8 first", {31'd0, mem_req}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 held", {31'd0, mem_req}, 32'h0);
    end
    reg_wr = 1'b0;
    access(1'b1, 8'h78, a, rq, we);
    chk("R8 once", {8'd0, a}, 32'h7E0201);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    nfail++;
    $display("FAIL watchdog actual=%0d expected=<20000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_sel = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_low;
    t_mid;
    t_high;
    t_stream;
    t_wrap;
    t_hold;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule